// File: doc/BRIEF.md
# Receive Message Queue with Software-Acknowledge Reply Pool

This block is the receiving end of a broadcast messaging fabric. Each incoming message is written as a 32-byte entry into a circular queue in memory. The queue occupies a window of entry slots bounded by a first index and a last index. Every accepted message takes one of eight software-acknowledge resources. The one-hot code of that resource is stamped into the entry, so that local software can see which resource to release. While any resource is waiting for software, an interrupt goes to the local processors. A message sent with its broadcast-interrupt flag set interrupts every local processor.

A reply goes back to the message's sender in one of two cases. In the first, software writes the acknowledge register to clear the resource's pending bit; the reply is then a normal reply and the resource is freed. In the second, the resource stays pending for too long. The hardware then sends one error reply and sets the resource's timeout bit. The resource stays held until software clears that timeout bit, and that clear sends no further reply. Incoming messages are held off when no resource is free or the queue window is full.

Top module: `pq_recv_unit`

## Requirements
- R1: An accepted message (msg_valid and msg_ready at a clock edge) drives qw_en high for the cycle that follows that edge. The entry it writes holds the payload in bytes 0-11, the header bits in bytes 12-14 and the supplemental bytes in bytes 16-17, and bytes 18-31 are zero.
- R2: Byte 15 (bits 127:120) of a written entry holds the one-hot code of the assigned resource: bit i is set for resource i.
- R3: Reset loads the tail index with cfg_first. Each write uses the tail index and then advances it by one, except that a write at cfg_last moves the tail back to cfg_first.
- R4: The free resource with the lowest index is assigned. msg_ready is low when all 8 resources are held, or when the number of held resources equals the window length cfg_last-cfg_first+1.
- R5: Writing ack_wdata with bit i (0-7) set while resource i is pending clears ack_state bit i. It also raises a reply with rep_err=0 to the stored sender, visible in the cycle after the write.
- R6: A resource that stays pending for TMO_CYCLES clock edges after its assigning edge loses its pending bit and gets timeout bit i+8 set in ack_state, both on that edge. At the same edge it raises exactly one reply with rep_err=1. The resource stays held, so it is not assigned again.
- R7: Writing bit i+8 while resource i is timed out clears that bit and frees the resource, with no reply.
- R8: A written bit whose pending or timeout bit is not set has no effect on ack_state, the replies or the interrupt.
- R9: irq[0] is high while any resource is pending. irq[k] for k>=1 is high only while a pending resource holds a message that had msg_int_all set.
- R10: A raised reply holds rep_valid until rep_ready is seen at an edge. The lowest-indexed waiting reply is presented first. A resource whose reply has not yet been taken stays held.
- R11: After reset, ack_state, irq, rep_valid and qw_en are zero and msg_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_first | input | IDXW | First entry index of the queue window |
| cfg_last | input | IDXW | Last entry index of the queue window |
| msg_valid | input | 1 | Incoming message present |
| msg_ready | output | 1 | Message can be accepted |
| msg_src | input | SRCW | Sender identity, used as the reply destination |
| msg_int_all | input | 1 | Interrupt all local processors |
| msg_payload | input | 96 | Message payload (12 bytes) |
| msg_hdr | input | 24 | Header bits carried into the entry |
| msg_supp | input | 16 | Supplemental bytes |
| qw_en | output | 1 | Queue entry write strobe |
| qw_idx | output | IDXW | Entry index written |
| qw_data | output | 256 | Entry contents |
| ack_wen | input | 1 | Acknowledge register write |
| ack_wdata | input | 2*NRES | Bits to clear: pending in [NRES-1:0], timeout above |
| ack_state | output | 2*NRES | Current pending and timeout bits |
| rep_valid | output | 1 | Reply present |
| rep_ready | input | 1 | Reply accepted |
| rep_dst | output | SRCW | Reply destination |
| rep_err | output | 1 | Reply caused by timeout |
| irq | output | NCPU | Interrupt per local processor |

## Verification
The entry write, the acknowledge state and the interrupt all change on the edge that accepts a message. They are sampled 1 ns after that edge. A reply caused by an acknowledge write is visible 1 ns after the edge that takes the write. A timeout is checked at two points: one edge before it is due (TMO_CYCLES-1 edges after the assigning edge), where the resource must still be pending, and on the edge where it falls due. All stimulus is driven on falling edges or just after a rising edge, so every sample falls between edges.

// File: rtl/pq_pkg.sv
// Package: shared constants and the entry layout of the receive queue.
// Assumes an entry of 32 bytes and a resource code that fits in one byte.
package pq_pkg;
    localparam int ENTRY_BITS = 256;
    localparam int PL_BITS    = 96;
    localparam int HDR_BITS   = 24;
    localparam int SUPP_BITS  = 16;
    localparam int CODE_BITS  = 8;

    // Builds one queue entry from the message fields and the resource code.
    function automatic logic [ENTRY_BITS-1:0] pack_entry(
        input logic [PL_BITS-1:0]   pl,
        input logic [HDR_BITS-1:0]  hdr,
        input logic [CODE_BITS-1:0] code,
        input logic [SUPP_BITS-1:0] supp);
        logic [ENTRY_BITS-1:0] e;
        e = '0;
        e[PL_BITS-1:0]                  = pl;
        e[PL_BITS +: HDR_BITS]          = hdr;
        e[PL_BITS+HDR_BITS +: CODE_BITS] = code;
        e[128 +: SUPP_BITS]             = supp;
        return e;
    endfunction
endpackage

// File: rtl/pq_ring_ptr.sv
// Module: tail index of the circular queue window, plus the room check.
// Assumes cfg_last >= cfg_first, and that both are held steady after reset.
module pq_ring_ptr #(
    parameter int IDXW = 5,
    parameter int CW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] first,
    input  logic [IDXW-1:0] last,
    input  logic            adv,
    input  logic [CW-1:0]   held_cnt,
    output logic [IDXW-1:0] tail,
    output logic            room
);
    localparam int LW = (IDXW > CW ? IDXW : CW) + 1;

    logic [LW-1:0] ring_len;

    // Window length, and room while fewer entries are held than it has.
    always_comb begin
        ring_len = LW'(last) - LW'(first) + LW'(1);
        room     = LW'(held_cnt) < ring_len;
    end

    // Advance the tail one entry per write, going back to first after last.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tail <= first;
        else if (adv)
            tail <= (tail == last) ? first : tail + IDXW'(1);
    end

    AST_TAIL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tail >= first) && (tail <= last)); // R3
endmodule

// File: rtl/pq_ack_slot.sv
// Module: one software-acknowledge resource. It holds the pending and
// timeout bits, the timeout counter, the stored sender and a reply request.
// Assumes alloc is raised only while busy is low.
module pq_ack_slot #(
    parameter int SRCW        = 8,
    parameter int TMO_CYCLES  = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc,
    input  logic [SRCW-1:0] src_in,
    input  logic            int_all_in,
    input  logic            clr_pend,
    input  logic            clr_tmo,
    input  logic            rep_take,
    output logic            pending,
    output logic            timed_out,
    output logic            rep_req,
    output logic            rep_is_err,
    output logic [SRCW-1:0] src,
    output logic            int_all,
    output logic            busy
);
    localparam int CNTW = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
    localparam logic [CNTW-1:0] CNT_END = CNTW'(TMO_CYCLES - 1);

    logic [CNTW-1:0] cnt;

    // Held from allocation until every bit and the reply are gone.
    always_comb busy = pending | timed_out | rep_req;

    // Move through pending, reply and timeout, counting the wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending    <= 1'b0;
            timed_out  <= 1'b0;
            rep_req    <= 1'b0;
            rep_is_err <= 1'b0;
            src        <= '0;
            int_all    <= 1'b0;
            cnt        <= '0;
        end else begin
            if (alloc) begin
                pending <= 1'b1;
                src     <= src_in;
                int_all <= int_all_in;
                cnt     <= '0;
            end else if (pending) begin
                if (clr_pend) begin
                    pending    <= 1'b0;
                    rep_req    <= 1'b1;
                    rep_is_err <= 1'b0;
                end else if (cnt == CNT_END) begin
                    pending    <= 1'b0;
                    timed_out  <= 1'b1;
                    rep_req    <= 1'b1;
                    rep_is_err <= 1'b1;
                end else begin
                    cnt <= cnt + CNTW'(1);
                end
            end
            if (timed_out && clr_tmo)
                timed_out <= 1'b0;
            if (rep_take)
                rep_req <= 1'b0;
        end
    end

    AST_REPLY_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rep_req) |-> $past(pending)); // R5
    AST_TMO_ERR_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timed_out) |-> (rep_req && rep_is_err && !pending)); // R6
    AST_TMO_CLEAR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timed_out) |-> !$rose(rep_req)); // R7
    AST_PENDING_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !(timed_out || rep_req)); // R6
endmodule

// File: rtl/pq_reply_arb.sv
// Module: picks the lowest-indexed waiting reply and returns the take strobe.
// Assumes the sender fields are packed with resource i at bits [i*SRCW +: SRCW].
module pq_reply_arb #(
    parameter int NRES = 8,
    parameter int SRCW = 8
) (
    input  logic [NRES-1:0]      req,
    input  logic [NRES-1:0]      err,
    input  logic [NRES*SRCW-1:0] srcs,
    input  logic                 rep_ready,
    output logic                 rep_valid,
    output logic [SRCW-1:0]      rep_dst,
    output logic                 rep_err,
    output logic [NRES-1:0]      take
);
    logic [NRES-1:0] grant;

    // Lowest index first, searched from the top down.
    always_comb begin
        grant   = '0;
        rep_dst = '0;
        rep_err = 1'b0;
        for (int i = NRES - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant   = '0;
                grant[i] = 1'b1;
                rep_dst = srcs[i*SRCW +: SRCW];
                rep_err = err[i];
            end
        end
        rep_valid = |req;
        take      = rep_ready ? grant : '0;
    end

    AST_GRANT_ONEHOT: assert final ($onehot0(grant)); // R10
endmodule

// File: rtl/pq_recv_unit.sv
// Module: top of the receive side. It accepts messages, assigns acknowledge
// resources, writes queue entries, drives the interrupts and sends the replies.
// Assumes cfg_first/cfg_last are steady from reset on, and NRES <= 8.
module pq_recv_unit #(
    parameter int QDEPTH     = 17,
    parameter int NRES       = 8,
    parameter int NCPU       = 4,
    parameter int SRCW       = 8,
    parameter int TMO_CYCLES = 64,
    parameter int IDXW       = $clog2(QDEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDXW-1:0]      cfg_first,
    input  logic [IDXW-1:0]      cfg_last,
    input  logic                 msg_valid,
    output logic                 msg_ready,
    input  logic [SRCW-1:0]      msg_src,
    input  logic                 msg_int_all,
    input  logic [95:0]          msg_payload,
    input  logic [23:0]          msg_hdr,
    input  logic [15:0]          msg_supp,
    output logic                 qw_en,
    output logic [IDXW-1:0]      qw_idx,
    output logic [255:0]         qw_data,
    input  logic                 ack_wen,
    input  logic [2*NRES-1:0]    ack_wdata,
    output logic [2*NRES-1:0]    ack_state,
    output logic                 rep_valid,
    input  logic                 rep_ready,
    output logic [SRCW-1:0]      rep_dst,
    output logic                 rep_err,
    output logic [NCPU-1:0]      irq
);
    import pq_pkg::*;

    localparam int CW = $clog2(NRES + 1);
    localparam int RW = (NRES > 1) ? $clog2(NRES) : 1;

    logic [NRES-1:0]      pend, tmo, rreq, rerr, busy, ib, take, alloc_vec;
    logic [NRES*SRCW-1:0] srcs;
    logic [CW-1:0]        held_cnt;
    logic [RW-1:0]        alloc_idx;
    logic                 any_free, room, accept;
    logic [IDXW-1:0]      tail;
    logic [CODE_BITS-1:0] code;

    // Lowest free resource and the number of resources held.
    always_comb begin
        any_free  = 1'b0;
        alloc_idx = '0;
        held_cnt  = '0;
        for (int i = NRES - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free  = 1'b1;
                alloc_idx = RW'(i);
            end
            held_cnt = held_cnt + CW'(busy[i]);
        end
    end

    // Handshake and the one-hot allocation strobe.
    always_comb begin
        msg_ready = any_free && room;
        accept    = msg_valid && msg_ready;
        alloc_vec = '0;
        if (accept)
            alloc_vec[alloc_idx] = 1'b1;
        code = '0;
        code[alloc_idx] = 1'b1;
    end

    pq_ring_ptr #(.IDXW(IDXW), .CW(CW)) u_ring (
        .clk(clk), .rst_n(rst_n), .first(cfg_first), .last(cfg_last),
        .adv(accept), .held_cnt(held_cnt), .tail(tail), .room(room)
    );

    for (genvar g = 0; g < NRES; g++) begin : g_slot
        pq_ack_slot #(.SRCW(SRCW), .TMO_CYCLES(TMO_CYCLES)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .alloc(alloc_vec[g]), .src_in(msg_src), .int_all_in(msg_int_all),
            .clr_pend(ack_wen && ack_wdata[g]),
            .clr_tmo(ack_wen && ack_wdata[NRES + g]),
            .rep_take(take[g]),
            .pending(pend[g]), .timed_out(tmo[g]), .rep_req(rreq[g]),
            .rep_is_err(rerr[g]), .src(srcs[g*SRCW +: SRCW]),
            .int_all(ib[g]), .busy(busy[g])
        );
    end

    pq_reply_arb #(.NRES(NRES), .SRCW(SRCW)) u_arb (
        .req(rreq), .err(rerr), .srcs(srcs), .rep_ready(rep_ready),
        .rep_valid(rep_valid), .rep_dst(rep_dst), .rep_err(rep_err),
        .take(take)
    );

    // Register the queue write for the cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qw_en   <= 1'b0;
            qw_idx  <= '0;
            qw_data <= '0;
        end else begin
            qw_en <= accept;
            if (accept) begin
                qw_idx  <= tail;
                qw_data <= pack_entry(msg_payload, msg_hdr, code, msg_supp);
            end
        end
    end

    // Register image and per-processor interrupts.
    always_comb ack_state = {tmo, pend};

    for (genvar c = 0; c < NCPU; c++) begin : g_irq
        if (c == 0) begin : g_home
            always_comb irq[c] = |pend;
        end else begin : g_other
            always_comb irq[c] = |(pend & ib);
        end
    end

    AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        qw_en |-> $onehot(qw_data[127:120])); // R2
    AST_IRQ_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        qw_en |-> irq[0]); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> $countones(ack_state[NRES-1:0]) >= 1); // R4
    AST_REPLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && !rep_ready) |=> rep_valid); // R10
endmodule

// File: tb/pq_recv_unit_test.sv
module pq_recv_unit_test;
    localparam int TMO  = 40;
    localparam int IDXW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [IDXW-1:0] cfg_first = '0, cfg_last = 5'd16;
    logic msg_valid = 1'b0, msg_ready, msg_int_all = 1'b0;
    logic [7:0] msg_src = '0;
    logic [95:0] msg_payload = '0;
    logic [23:0] msg_hdr = '0;
    logic [15:0] msg_supp = '0;
    logic qw_en;
    logic [IDXW-1:0] qw_idx;
    logic [255:0] qw_data;
    logic ack_wen = 1'b0;
    logic [15:0] ack_wdata = '0, ack_state;
    logic rep_valid, rep_ready = 1'b0, rep_err;
    logic [7:0] rep_dst;
    logic [3:0] irq;

    int nchk = 0, nfail = 0, cyc = 0;
    logic [IDXW-1:0] exp_tail;
    bit took;
    logic cap_en;
    logic [IDXW-1:0] cap_idx;
    logic [255:0] cap_data;

    always #2.5 clk = ~clk;

    pq_recv_unit #(.TMO_CYCLES(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_first(cfg_first), .cfg_last(cfg_last),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_src(msg_src),
        .msg_int_all(msg_int_all), .msg_payload(msg_payload),
        .msg_hdr(msg_hdr), .msg_supp(msg_supp), .qw_en(qw_en),
        .qw_idx(qw_idx), .qw_data(qw_data), .ack_wen(ack_wen),
        .ack_wdata(ack_wdata), .ack_state(ack_state), .rep_valid(rep_valid),
        .rep_ready(rep_ready), .rep_dst(rep_dst), .rep_err(rep_err), .irq(irq)
    );

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] entry(input logic [95:0] pl, input logic [23:0] hd,
                                           input logic [7:0] code, input logic [15:0] sp);
        return {112'd0, sp, code, hd, pl};
    endfunction

    task automatic do_reset(input logic [IDXW-1:0] f, input logic [IDXW-1:0] l);
        @(negedge clk);
        rst_n = 1'b0; cfg_first = f; cfg_last = l;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        exp_tail = f;
    endtask

    task automatic send(input logic [7:0] src, input bit ia, input logic [95:0] pl,
                        input logic [23:0] hd, input logic [15:0] sp);
        @(negedge clk);
        msg_valid = 1'b1; msg_src = src; msg_int_all = ia;
        msg_payload = pl; msg_hdr = hd; msg_supp = sp;
        took = msg_ready;
        @(posedge clk); #1;
        msg_valid = 1'b0;
        cap_en = qw_en; cap_idx = qw_idx; cap_data = qw_data;
        if (took) begin
            check("R1 write strobe", 256'(cap_en), 256'(1));
            check("R3 tail index", 256'(cap_idx), 256'(exp_tail));
            exp_tail = (exp_tail == cfg_last) ? cfg_first : exp_tail + 1'b1;
        end
    endtask

    task automatic ack(input logic [15:0] d);
        @(negedge clk);
        ack_wen = 1'b1; ack_wdata = d;
        @(posedge clk); #1;
        ack_wen = 1'b0;
    endtask

    task automatic take(input string req, input logic [7:0] dst, input bit err);
        @(negedge clk);
        check({req, " reply valid"}, 256'(rep_valid), 256'(1));
        check({req, " reply dst"}, 256'(rep_dst), 256'(dst));
        check({req, " reply err"}, 256'(rep_err), 256'(err));
        rep_ready = 1'b1;
        @(posedge clk); #1;
        rep_ready = 1'b0;
    endtask

    task automatic t_reset_state;
        check("R11 ack_state", 256'(ack_state), 256'(0));
        check("R11 irq", 256'(irq), 256'(0));
        check("R11 rep_valid", 256'(rep_valid), 256'(0));
        check("R11 qw_en", 256'(qw_en), 256'(0));
        check("R11 msg_ready", 256'(msg_ready), 256'(1));
    endtask

    task automatic t_format;
        send(8'h21, 1'b0, 96'hA1A2A3A4A5A6A7A8A9AAABAC, 24'hC1C2C3, 16'hD1D2);
        check("R1 R2 entry 0", cap_data, entry(96'hA1A2A3A4A5A6A7A8A9AAABAC, 24'hC1C2C3, 8'h01, 16'hD1D2));
        send(8'h22, 1'b0, 96'h5, 24'h6, 16'h7);
        check("R2 R4 entry 1 code", cap_data, entry(96'h5, 24'h6, 8'h02, 16'h7));
        check("R4 pending bits", 256'(ack_state), 256'(16'h0003));
        ack(16'h0003);
        check("R5 pending cleared", 256'(ack_state), 256'(0));
        take("R5 R10 first", 8'h21, 1'b0);
        take("R5 R10 second", 8'h22, 1'b0);
        check("R10 reply queue empty", 256'(rep_valid), 256'(0));
    endtask

    task automatic t_no_effect;
        send(8'h30, 1'b0, 96'h1, 24'h1, 16'h1);
        ack(16'h0102);
        check("R8 state unchanged", 256'(ack_state), 256'(16'h0001));
        check("R8 no reply", 256'(rep_valid), 256'(0));
        check("R8 irq unchanged", 256'(irq), 256'(4'b0001));
        ack(16'h0001);
        take("R5 clean", 8'h30, 1'b0);
    endtask

    task automatic t_irq;
        send(8'h40, 1'b0, 96'h2, 24'h2, 16'h2);
        check("R9 home only", 256'(irq), 256'(4'b0001));
        send(8'h41, 1'b1, 96'h3, 24'h3, 16'h3);
        check("R9 all cpus", 256'(irq), 256'(4'b1111));
        ack(16'h0002);
        check("R9 back to home", 256'(irq), 256'(4'b0001));
        ack(16'h0001);
        check("R9 none pending", 256'(irq), 256'(4'b0000));
        take("R10 lower first", 8'h40, 1'b0);
        take("R10 next", 8'h41, 1'b0);
    endtask

    task automatic t_all_held;
        for (int i = 0; i < 8; i++) begin
            send(8'h50 + 8'(i), 1'b0, 96'(i), 24'(i), 16'(i));
            check("R2 R4 lowest free", 256'(cap_data[127:120]), 256'(8'h01 << i));
        end
        check("R4 no resource free", 256'(msg_ready), 256'(0));
        send(8'h5F, 1'b0, 96'h9, 24'h9, 16'h9);
        check("R4 refused no write", 256'(cap_en), 256'(0));
        ack(16'h00FF);
        for (int i = 0; i < 8; i++)
            take("R10 order", 8'h50 + 8'(i), 1'b0);
        check("R10 all taken", 256'(rep_valid), 256'(0));
    endtask

    task automatic t_timeout;
        send(8'h60, 1'b0, 96'h4, 24'h4, 16'h4);
        repeat (TMO - 1) @(posedge clk);
        #1;
        check("R6 still pending", 256'(ack_state), 256'(16'h0001));
        check("R6 no early reply", 256'(rep_valid), 256'(0));
        @(posedge clk); #1;
        check("R6 timeout bit", 256'(ack_state), 256'(16'h0100));
        check("R9 irq drops", 256'(irq[0]), 256'(0));
        take("R6 error reply", 8'h60, 1'b1);
        check("R6 one reply only", 256'(rep_valid), 256'(0));
        send(8'h61, 1'b0, 96'h8, 24'h8, 16'h8);
        check("R6 resource still held", 256'(cap_data[127:120]), 256'(8'h02));
        ack(16'h0002);
        take("R5 clean", 8'h61, 1'b0);
        ack(16'h0001);
        check("R8 pending clear on timed out", 256'(ack_state), 256'(16'h0100));
        ack(16'h0100);
        check("R7 freed", 256'(ack_state), 256'(0));
        @(posedge clk); #1;
        check("R7 no reply", 256'(rep_valid), 256'(0));
    endtask

    task automatic t_window;
        do_reset(5'd2, 5'd5);
        check("R3 reset no write", 256'(qw_en), 256'(0));
        for (int i = 0; i < 4; i++)
            send(8'h70 + 8'(i), 1'b0, 96'(i), 24'(i), 16'(i));
        check("R4 window full", 256'(msg_ready), 256'(0));
        ack(16'h0001);
        take("R5 window", 8'h70, 1'b0);
        check("R4 room again", 256'(msg_ready), 256'(1));
        send(8'h7A, 1'b0, 96'hB, 24'hB, 16'hB);
        check("R3 wrap to first", 256'(cap_idx), 256'(2));
        check("R4 reused lowest", 256'(cap_data[127:120]), 256'(8'h01));
        ack(16'h000F);
        take("R10 a", 8'h7A, 1'b0);
        take("R10 b", 8'h71, 1'b0);
        take("R10 c", 8'h72, 1'b0);
        take("R10 d", 8'h73, 1'b0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        do_reset(5'd0, 5'd16);
        t_reset_state();
        t_format();
        t_no_effect();
        t_irq();
        t_all_held();
        t_timeout();
        t_window();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule